// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation-buffer miss by searching a hashed page table in memory. The table is a flat array of groups, and each group holds eight 16-byte entries (128 bytes). Each entry records the virtual page it maps, so a lookup must compare tags. When a request is accepted, the walker captures the table base address and the group count from the configuration inputs.

The walker hashes the virtual page number to a primary group and reads that group's entries one at a time over a read-request/read-response port. It stops at the first valid entry whose tag matches. If all eight primary entries miss, it derives a secondary group from a second hash and scans that group the same way. It ends every walk with a single-cycle completion pulse. The pulse carries either a fill (virtual page to physical page, after which the access is retried) or a page fault.

Requests use a valid/ready pair. `req_ready` is high only while the walker is idle, and a request is taken in a cycle where both `req_valid` and `req_ready` are high. Read requests also use valid/ready, and the memory may stall them by holding `mem_rd_ready` low. Only one read is ever outstanding. A response is taken whenever `mem_rsp_valid` is high while the walker waits for one, so it needs no ready signal.

Top module: `hpt_walker`

## Requirements
- R1: While idle, `req_ready` is high and `busy` is low. A request is accepted when `req_valid` and `req_ready` are both high, and `busy` is high from the next cycle. `req_valid` pulses seen while busy start no walk and produce no extra completion.
- R2: `cfg_base` and `cfg_groups` are sampled only at acceptance, so changes during a walk do not alter its read addresses. A group count of 0 behaves as a count of 1.
- R3: The primary group index is the virtual page number modulo k. The address of slot s in group g is base + g*128 + s*16.
- R4: Entry bit 127 is the valid bit, bits [64 +: VPN_W] hold the page tag, and bits [0 +: PPN_W] hold the physical page. An entry matches only when it is valid and its tag equals the requested page.
- R5: Slots are read in ascending order from 0 to 7. The scan stops at the first match, so the lowest matching slot supplies the result.
- R6: A match completes the walk with `done_fault` at 0 and `done_ppn` equal to the entry's physical page. `done_vpn` always carries the requested page.
- R7: The secondary group index is the 12-bit (GRP_W) complement of the primary index, reduced modulo k. The secondary group is read only after all eight primary slots miss.
- R8: When both groups miss, the walk completes after exactly 16 reads, with `done_fault` at 1 and `done_ppn` at 0.
- R9: `done` is high for exactly one cycle, while `busy` is still high, and `busy` is low in the following cycle.
- R10: While `mem_rd_valid` is high and `mem_rd_ready` is low, the read request and its address hold steady. Reads are issued only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vpn | input | VPN_W | Virtual page number to resolve |
| busy | output | 1 | Walk in progress |
| cfg_base | input | ADDR_W | Byte address of the table |
| cfg_groups | input | GRP_W | Number of groups k (0 treated as 1) |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | ADDR_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | One table entry |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a page fault |
| done_vpn | output | VPN_W | Requested page of the completed walk |
| done_ppn | output | PPN_W | Physical page of the fill (0 on fault) |

## Verification
The hardest case to reach is a hit in the secondary group at the last slot. That walk needs eight primary misses, a correct complement-and-modulo hash at a group count that is not a power of two, and sixteen ordered reads. The stimulus builds it directly: it fills the primary group with valid entries carrying other tags, plants the match in the secondary group's final slot, and runs with k=5. Every read address is checked against a queue computed from the hash rules. Two other cases are also set up. In one, requests and configuration changes are injected in the middle of a long walk. In the other, the read handshake stalls by a varying number of cycles, so both the ignore rules and the held-request rule are exercised.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int ENTRY_W      = 128;
  localparam int ENTRY_BYTES  = 16;
  localparam int SLOTS        = 8;
  localparam int GROUP_BYTES  = ENTRY_BYTES * SLOTS;
  localparam int SLOT_W       = $clog2(SLOTS);
  localparam int ENTRY_SHIFT  = $clog2(ENTRY_BYTES);
  localparam int GROUP_SHIFT  = $clog2(GROUP_BYTES);
  localparam int VALID_BIT    = 127;
  localparam int TAG_LSB      = 64;
  localparam int PPN_LSB      = 0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } walk_state_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VPN_W = 20,
  parameter int GRP_W = 12
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [GRP_W-1:0] groups,
  output logic [GRP_W-1:0] prim_idx,
  output logic [GRP_W-1:0] sec_idx
);
  localparam int W = (VPN_W > GRP_W) ? VPN_W : GRP_W;

  logic [GRP_W-1:0] k_eff;
  logic [W-1:0]     k_w;
  logic [W-1:0]     prim_w;
  logic [W-1:0]     sec_w;
  logic [GRP_W-1:0] prim_inv;

  assign k_eff    = (groups == '0) ? GRP_W'(1) : groups;
  assign k_w      = W'(k_eff);
  assign prim_w   = W'(vpn) % k_w;
  assign prim_idx = prim_w[GRP_W-1:0];
  assign prim_inv = ~prim_idx;
  assign sec_w    = W'(prim_inv) % k_w;
  assign sec_idx  = sec_w[GRP_W-1:0];
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
  import hpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GRP_W  = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [GRP_W-1:0]  group_idx,
  input  logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] group_off;
  logic [ADDR_W-1:0] slot_off;

  assign group_off = ADDR_W'(group_idx) << GROUP_SHIFT;
  assign slot_off  = ADDR_W'(slot) << ENTRY_SHIFT;
  assign addr      = base + group_off + slot_off;
endmodule

// File: rtl/hpt_entry_cmp.sv
module hpt_entry_cmp
  import hpt_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 24
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [VPN_W-1:0]   vpn,
  output logic               hit,
  output logic [PPN_W-1:0]   ppn
);
  logic unused_entry_bits;

  assign hit = entry[VALID_BIT] && (entry[TAG_LSB +: VPN_W] == vpn);
  assign ppn = entry[PPN_LSB +: PPN_W];
  assign unused_entry_bits = ^entry;
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 24,
  parameter int ADDR_W = 32,
  parameter int GRP_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  output logic               busy,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [GRP_W-1:0]   cfg_groups,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               done,
  output logic               done_fault,
  output logic [VPN_W-1:0]   done_vpn,
  output logic [PPN_W-1:0]   done_ppn
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  walk_state_e       state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] base_q;
  logic [GRP_W-1:0]  groups_q;
  logic              probe_q;
  logic [SLOT_W-1:0] slot_q;
  logic              fault_q;
  logic [PPN_W-1:0]  ppn_q;

  logic [GRP_W-1:0]  prim_idx;
  logic [GRP_W-1:0]  sec_idx;
  logic [GRP_W-1:0]  cur_idx;
  logic              ent_hit;
  logic [PPN_W-1:0]  ent_ppn;

  hpt_hash #(.VPN_W(VPN_W), .GRP_W(GRP_W)) u_hash (
    .vpn      (vpn_q),
    .groups   (groups_q),
    .prim_idx (prim_idx),
    .sec_idx  (sec_idx)
  );

  assign cur_idx = probe_q ? sec_idx : prim_idx;

  hpt_addr_gen #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_addr (
    .base      (base_q),
    .group_idx (cur_idx),
    .slot      (slot_q),
    .addr      (mem_rd_addr)
  );

  hpt_entry_cmp #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_cmp (
    .entry (mem_rsp_data),
    .vpn   (vpn_q),
    .hit   (ent_hit),
    .ppn   (ent_ppn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      vpn_q    <= '0;
      base_q   <= '0;
      groups_q <= '0;
      probe_q  <= 1'b0;
      slot_q   <= '0;
      fault_q  <= 1'b0;
      ppn_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q    <= req_vpn;
            base_q   <= cfg_base;
            groups_q <= cfg_groups;
            probe_q  <= 1'b0;
            slot_q   <= '0;
            state_q  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_rd_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (ent_hit) begin
              fault_q <= 1'b0;
              ppn_q   <= ent_ppn;
              state_q <= ST_FINISH;
            end else if (slot_q == SLOT_LAST) begin
              if (!probe_q) begin
                probe_q <= 1'b1;
                slot_q  <= '0;
                state_q <= ST_ISSUE;
              end else begin
                fault_q <= 1'b1;
                ppn_q   <= '0;
                state_q <= ST_FINISH;
              end
            end else begin
              slot_q  <= slot_q + SLOT_W'(1);
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign busy         = (state_q != ST_IDLE);
  assign mem_rd_valid = (state_q == ST_ISSUE);
  assign done         = (state_q == ST_FINISH);
  assign done_fault   = fault_q;
  assign done_vpn     = vpn_q;
  assign done_ppn     = ppn_q;
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              done
);
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_done_inside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_rd_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> busy);
endmodule

bind hpt_walker hpt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;
  localparam int VPN_W  = 20;
  localparam int PPN_W  = 24;
  localparam int ADDR_W = 32;
  localparam int GRP_W  = 12;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic             fault;
    logic [PPN_W-1:0] ppn;
    int               nreads;
  } result_t;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [VPN_W-1:0]   req_vpn = '0;
  logic               busy;
  logic [ADDR_W-1:0]  cfg_base = '0;
  logic [GRP_W-1:0]   cfg_groups = '0;
  logic               mem_rd_valid;
  logic               mem_rd_ready = 1'b0;
  logic [ADDR_W-1:0]  mem_rd_addr;
  logic               mem_rsp_valid = 1'b0;
  logic [127:0]       mem_rsp_data = '0;
  logic               done;
  logic               done_fault;
  logic [VPN_W-1:0]   done_vpn;
  logic [PPN_W-1:0]   done_ppn;

  int checks = 0;
  int fails  = 0;
  int rd_count = 0;
  int rd_total = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [127:0]      mem [logic [31:0]];
  result_t           exp_q [$];
  logic [ADDR_W-1:0] addr_q [$];

  always #2 clk = ~clk;

  hpt_walker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_hpt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .busy(busy), .cfg_base(cfg_base), .cfg_groups(cfg_groups),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
    .done_fault(done_fault), .done_vpn(done_vpn), .done_ppn(done_ppn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] ent_addr(input logic [ADDR_W-1:0] base,
      input logic [GRP_W-1:0] g, input int s);
    return base + (ADDR_W'(g) * 128) + ADDR_W'(s * 16);
  endfunction

  task automatic put(input logic [ADDR_W-1:0] base, input logic [GRP_W-1:0] g, input int s,
                     input bit v, input logic [VPN_W-1:0] tag, input logic [PPN_W-1:0] ppn);
    logic [127:0] e;
    e = '0;
    e[127] = v;
    e[64 +: VPN_W] = tag;
    e[0 +: PPN_W] = ppn;
    mem[ent_addr(base, g, s)] = e;
  endtask

  function automatic logic [127:0] rd_mem(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return '0;
  endfunction

  // Expected walk computed from the hash and scan rules (R3, R5, R7, R8)
  task automatic expect_walk(input logic [VPN_W-1:0] vpn, input logic [ADDR_W-1:0] base,
                             input logic [GRP_W-1:0] k);
    int keff;
    logic [GRP_W-1:0] idx [2];
    logic [GRP_W-1:0] inv;
    result_t r;
    bit found;
    logic [127:0] e;
    keff = (k == 0) ? 1 : int'(k);
    idx[0] = GRP_W'(int'(vpn) % keff);
    inv = ~idx[0];
    idx[1] = GRP_W'(int'(inv) % keff);
    r.vpn = vpn; r.fault = 1'b1; r.ppn = '0; r.nreads = 0;
    found = 1'b0;
    for (int p = 0; p < 2 && !found; p++) begin
      for (int s = 0; s < 8 && !found; s++) begin
        addr_q.push_back(ent_addr(base, idx[p], s));
        r.nreads++;
        e = rd_mem(ent_addr(base, idx[p], s));
        if (e[127] && e[64 +: VPN_W] == vpn) begin
          found = 1'b1; r.fault = 1'b0; r.ppn = e[0 +: PPN_W];
        end
      end
    end
    exp_q.push_back(r);
  endtask

  task automatic issue(input logic [VPN_W-1:0] vpn);
    while (!req_ready) @(negedge clk);
    expect_walk(vpn, cfg_base, cfg_groups);
    req_vpn = vpn;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // Memory model with varying stalls on the read handshake (R10)
  initial begin
    int stall;
    int lat;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_rd_valid) begin
        stall = rd_total % 3;
        lat = rd_total % 2;
        rd_total++;
        repeat (stall) @(negedge clk);
        mem_rd_ready = 1'b1;
        if (addr_q.size() == 0) chk(1'b0, "R3", "unexpected read", 64'(mem_rd_addr), 64'd0);
        else begin
          logic [ADDR_W-1:0] ea;
          ea = addr_q.pop_front();
          chk(mem_rd_addr == ea, "R3", "read address", 64'(mem_rd_addr), 64'(ea));
        end
        mem_rsp_data = rd_mem(mem_rd_addr);
        rd_count++;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
      end
    end
  end

  // Scoreboard monitor (R6, R8, R9)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected done", 64'(done_vpn), 64'd0);
        else begin
          result_t r;
          r = exp_q.pop_front();
          chk(done_vpn == r.vpn, "R6", "done_vpn", 64'(done_vpn), 64'(r.vpn));
          chk(done_fault == r.fault, "R8", "done_fault", 64'(done_fault), 64'(r.fault));
          chk(done_ppn == r.ppn, "R6", "done_ppn", 64'(done_ppn), 64'(r.ppn));
          chk(rd_count == r.nreads, "R5", "read count", 64'(rd_count), 64'(r.nreads));
          chk(busy == 1'b1, "R9", "busy with done", 64'(busy), 64'd1);
        end
        rd_count = 0;
        @(negedge clk);
        chk(!done && !busy, "R9", "done/busy after pulse", {62'd0, done, busy}, 64'd0);
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
      report();
    end
  end

  localparam logic [ADDR_W-1:0] B1 = 32'h1000_0000;
  localparam logic [ADDR_W-1:0] B2 = 32'h2000_0000;
  localparam logic [ADDR_W-1:0] B3 = 32'h3000_0000;
  localparam logic [ADDR_W-1:0] B4 = 32'h4000_0000;

  initial begin
    // Table contents, k=16 at B1
    put(B1, 3, 0, 1, 20'h00123, 24'hABC01);                 // R6 slot 0 hit
    put(B1, 5, 1, 1, 20'h00999, 24'h00011);                 // R4 wrong tag
    put(B1, 5, 2, 0, 20'h00245, 24'h00022);                 // R4 invalid match
    put(B1, 5, 5, 1, 20'h00245, 24'h00055);
    put(B1, 7, 3, 1, 20'h00367, 24'h00033);                 // R5 first of two
    put(B1, 7, 6, 1, 20'h00367, 24'h00066);
    for (int s = 0; s < 8; s++) put(B1, 9, s, 1, 20'h00100 + 20'(s), 24'h1);  // R7 full miss
    put(B1, 6, 4, 1, 20'h00489, 24'h00644);
    // k=5 at B2: vpn 0xD -> primary 3, secondary 2, hit in last slot
    for (int s = 0; s < 8; s++) put(B2, 3, s, 1, 20'h00200, 24'h2);
    put(B2, 2, 7, 1, 20'h0000D, 24'h0D0D7);
    // k=0 treated as 1 at B3
    put(B3, 0, 2, 1, 20'h00777, 24'h00777);
    // R2 mid-walk config change: vpn 0x13 at k=16 -> primary 3, secondary 12
    put(B1, 12, 1, 1, 20'h00013, 24'h01312);
    put(B4, 3, 0, 1, 20'h00013, 24'hBAD00);

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", 64'(req_ready), 64'd1);
    chk(busy == 1'b0, "R1", "reset busy", 64'(busy), 64'd0);
    chk(done == 1'b0, "R9", "reset done", 64'(done), 64'd0);
    chk(mem_rd_valid == 1'b0, "R10", "reset rd_valid", 64'(mem_rd_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_base = B1; cfg_groups = 12'd16;
    issue(20'h00123); wait_idle();     // R6 primary slot 0
    issue(20'h00245); wait_idle();     // R4 invalid skipped, slot 5
    issue(20'h00367); wait_idle();     // R5 lowest slot wins
    issue(20'h00489); wait_idle();     // R7 secondary hit
    issue(20'h005AB); wait_idle();     // R8 fault

    cfg_base = B2; cfg_groups = 12'd5;
    issue(20'h0000D); wait_idle();     // R7 k=5, last secondary slot
    cfg_base = B3; cfg_groups = 12'd0;
    issue(20'h00777); wait_idle();     // R2 k=0 as 1

    // R1: requests while busy are ignored
    cfg_base = B1; cfg_groups = 12'd16;
    issue(20'h00ABC);
    repeat (3) @(negedge clk);
    req_vpn = 20'h00123; req_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R1", "still busy during injected request", 64'(busy), 64'd1);
    chk(req_ready == 1'b0, "R1", "req_ready low while busy", 64'(req_ready), 64'd0);
    req_valid = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R1", "idle after ignored request", 64'(busy), 64'd0);

    // R2: configuration changed mid-walk does not alter the walk
    issue(20'h00013);
    @(negedge clk);
    cfg_base = B4; cfg_groups = 12'd7;
    wait_idle();
    repeat (10) @(negedge clk);

    chk(exp_q.size() == 0, "R9", "pending completions", 64'(exp_q.size()), 64'd0);
    chk(addr_q.size() == 0, "R5", "pending reads", 64'(addr_q.size()), 64'd0);
    report();
  end
endmodule